// File: doc/BRIEF.md
# Periodic CAS-before-RAS Refresh Engine

This block keeps an EDO DRAM array alive without help from the access path. A free-running interval timer produces one refresh credit per row slot: the retention period divided by the row count, expressed in clock cycles. The credits collect in a bounded pending counter, and the engine raises a request whenever at least one credit is waiting. When the access controller answers with a grant, the engine takes the DRAM strobes and runs one refresh cycle. It then holds a busy flag through the RAS precharge, so the next normal access cannot begin too soon.

In the default mode the cycle is CAS-before-RAS. CAS drops first, then RAS falls while CAS is still low. WE stays high the whole time, so the devices never see the test-mode entry combination. The DRAM's internal counter picks the row. A parameter selects the alternative mode instead. In that mode CAS stays high, RAS is pulsed alone, and a row address comes from an internal counter that steps after every refresh and wraps at the row count. If credits arrive faster than grants, the pending counter saturates and a sticky error flag records the lost refresh.

Top module: `refresh_cbr_sched`

## Requirements
- R1: The interval timer adds one pending refresh every INTERVAL_CYC clock cycles, with no drift. Two successive rises of `ref_req`, each following a point where the pending count had fallen to zero, are exactly INTERVAL_CYC cycles apart.
- R2: `ref_req` is high exactly while the pending count is non-zero, and each accepted grant removes one credit. A grant that arrives while `ref_req` is low starts nothing.
- R3: The pending count saturates at MAX_PEND. A timer credit that arrives while the count is full sets `ovf_err`, which stays set until reset.
- R4: In CAS-before-RAS mode, `cas_n` goes low in the first cycle after the grant edge. It stays low for CSR_CYC cycles with `ras_n` high before `ras_n` falls.
- R5: In CAS-before-RAS mode, `cas_n` stays low for CHR_CYC cycles after `ras_n` falls. It is back high at least one cycle before `ras_n` rises.
- R6: `we_n` is high in every cycle, including the whole refresh sequence.
- R7: `ras_n` is low for exactly RAS_CYC cycles per refresh and is then high for RP_CYC precharge cycles before the engine returns to idle.
- R8: `busy` is high from the cycle after the grant edge until the last precharge cycle. It is low otherwise. While `busy` is low, `ras_n` and `cas_n` are high.
- R9: In RAS-only mode (RAS_ONLY=1), `cas_n` stays high throughout. `ras_n` is low for RAS_CYC cycles, and `row_addr` is stable while `ras_n` is low.
- R10: In RAS-only mode, `row_addr` starts at 0 and increments by one after each refresh, wrapping from ROWS-1 to 0. In CAS-before-RAS mode it is 0.
- R11: During reset, `ras_n`, `cas_n` and `we_n` are high, and `busy`, `ref_req` and `ovf_err` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ref_gnt | input | 1 | Grant from the access controller |
| ref_req | output | 1 | Refresh credit pending |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low (held high) |
| row_addr | output | $clog2(ROWS) | Row address for RAS-only mode, 0 otherwise |
| busy | output | 1 | Engine owns the strobes |
| ovf_err | output | 1 | Sticky lost-refresh flag |

## Verification
Every strobe of a refresh is compared cycle by cycle against a fixed pattern in both modes. An engine that dropped RAS before or together with CAS would do a RAS-only refresh or a plain access instead of a CAS-before-RAS cycle. One that released `busy` before precharge ended would let an access violate the precharge time. The bench sends a grant with no credit waiting, drains two stacked credits one by one, and fills the pending count until one more tick must set the sticky overflow. It also runs nine RAS-only refreshes, so the row counter must wrap from 7 to 0 rather than run into unused address bits.

// File: rtl/refresh_pkg.sv
package refresh_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_CSETUP = 2'd1,
    ST_RASACT = 2'd2,
    ST_PRECH  = 2'd3
  } ref_state_e;
endpackage

// File: rtl/refresh_interval_timer.sv
module refresh_interval_timer #(
  parameter int INTERVAL_CYC = 781
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = $clog2(INTERVAL_CYC + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == CW'(INTERVAL_CYC - 1));

  always_comb begin
    if (tick) cnt_d = '0;
    else      cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R1: a credit is a single-cycle event, never two in a row
  assert_tick_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/refresh_pending_ctr.sv
module refresh_pending_ctr #(
  parameter int MAX_PEND = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic take,
  output logic req,
  output logic ovf_err
);
  localparam int PW = $clog2(MAX_PEND + 1);

  logic [PW-1:0] pend_q, pend_d;
  logic          ovf_q, ovf_d;
  logic          full;

  assign full    = (pend_q == PW'(MAX_PEND));
  assign req     = (pend_q != '0);
  assign ovf_err = ovf_q;

  always_comb begin
    pend_d = pend_q;
    ovf_d  = ovf_q;
    unique case ({tick, take})
      2'b10: begin
        if (full) ovf_d  = 1'b1;
        else      pend_d = pend_q + PW'(1);
      end
      2'b01:   pend_d = pend_q - PW'(1);
      default: pend_d = pend_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      ovf_q  <= ovf_d;
    end
  end

  // R3: a credit arriving while the count is full is recorded as lost
  assert_overflow_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !take && full) |=> ovf_err);
  // R3: the error flag is sticky
  assert_overflow_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |=> ovf_err);
  // R2: the sequencer consumes only credits that exist
  assert_take_needs_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> req);
endmodule

// File: rtl/refresh_strobe_seq.sv
module refresh_strobe_seq
  import refresh_pkg::*;
#(
  parameter bit RAS_ONLY = 1'b0,
  parameter int CSR_CYC  = 1,
  parameter int CHR_CYC  = 1,
  parameter int RAS_CYC  = 3,
  parameter int RP_CYC   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic gnt,
  output logic take,
  output logic row_step,
  output logic ras_n,
  output logic cas_n,
  output logic busy
);
  localparam int MAXC = (RAS_CYC > CSR_CYC) ?
                        ((RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC) :
                        ((CSR_CYC > RP_CYC) ? CSR_CYC : RP_CYC);
  localparam int TW = $clog2(MAXC + 1);

  ref_state_e    st_q, st_d;
  logic [TW-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q + TW'(1);
    take     = 1'b0;
    row_step = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        cnt_d = '0;
        if (req && gnt) begin
          take = 1'b1;
          st_d = RAS_ONLY ? ST_RASACT : ST_CSETUP;
        end
      end
      ST_CSETUP: begin
        if (cnt_q == TW'(CSR_CYC - 1)) begin
          st_d  = ST_RASACT;
          cnt_d = '0;
        end
      end
      ST_RASACT: begin
        if (cnt_q == TW'(RAS_CYC - 1)) begin
          st_d     = ST_PRECH;
          cnt_d    = '0;
          row_step = 1'b1;
        end
      end
      ST_PRECH: begin
        if (cnt_q == TW'(RP_CYC - 1)) begin
          st_d  = ST_IDLE;
          cnt_d = '0;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ras_n = (st_q != ST_RASACT);
  assign busy  = (st_q != ST_IDLE);

  generate
    if (RAS_ONLY) begin : g_ras_only
      assign cas_n = 1'b1;
      // R9: the column strobe never moves in this mode
      assert_cas_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> cas_n);
    end else begin : g_cbr
      assign cas_n = !((st_q == ST_CSETUP) ||
                       ((st_q == ST_RASACT) && (cnt_q < TW'(CHR_CYC))));
      // R4: CAS already low in the cycle before RAS falls
      assert_cas_before_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n) |-> (!cas_n && !$past(cas_n)));
      // R5: CAS released at least a cycle before RAS rises
      assert_cas_released_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ras_n) |-> (cas_n && $past(cas_n)));
    end
  endgenerate

  // R8: the engine only leaves idle on a granted credit
  assert_start_on_grant_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req && gnt));
  // R8: idle strobes are inactive
  assert_idle_strobes_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (ras_n && cas_n));
endmodule

// File: rtl/refresh_row_ctr.sv
module refresh_row_ctr #(
  parameter int ROWS = 4096
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int RW = $clog2(ROWS);

  logic [RW-1:0] row_q, row_d;
  logic          last;

  assign last = (row_q == RW'(ROWS - 1));
  assign row  = row_q;

  always_comb begin
    row_d = row_q;
    if (step) row_d = last ? '0 : row_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) row_q <= '0;
    else        row_q <= row_d;
  end

  // R10: wrap back to row zero after the last row
  assert_row_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last) |=> (row == '0));
  // R10: the row only moves on a completed refresh
  assert_row_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(row));
endmodule

// File: rtl/refresh_cbr_sched.sv
module refresh_cbr_sched #(
  parameter int ROWS         = 4096,
  parameter int INTERVAL_CYC = 781,
  parameter int MAX_PEND     = 8,
  parameter int CSR_CYC      = 1,
  parameter int CHR_CYC      = 1,
  parameter int RAS_CYC      = 3,
  parameter int RP_CYC       = 2,
  parameter bit RAS_ONLY     = 1'b0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ref_gnt,
  output logic                    ref_req,
  output logic                    ras_n,
  output logic                    cas_n,
  output logic                    we_n,
  output logic [$clog2(ROWS)-1:0] row_addr,
  output logic                    busy,
  output logic                    ovf_err
);
  localparam int RW = $clog2(ROWS);

  logic rst_meta_q, rst_sync_q;
  logic tick, take, row_step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  refresh_interval_timer #(.INTERVAL_CYC(INTERVAL_CYC)) u_timer (
    .clk  (clk),
    .rst_n(rst_sync_q),
    .tick (tick)
  );

  refresh_pending_ctr #(.MAX_PEND(MAX_PEND)) u_pend (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .tick   (tick),
    .take   (take),
    .req    (ref_req),
    .ovf_err(ovf_err)
  );

  refresh_strobe_seq #(
    .RAS_ONLY(RAS_ONLY),
    .CSR_CYC (CSR_CYC),
    .CHR_CYC (CHR_CYC),
    .RAS_CYC (RAS_CYC),
    .RP_CYC  (RP_CYC)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .req     (ref_req),
    .gnt     (ref_gnt),
    .take    (take),
    .row_step(row_step),
    .ras_n   (ras_n),
    .cas_n   (cas_n),
    .busy    (busy)
  );

  generate
    if (RAS_ONLY) begin : g_rows
      refresh_row_ctr #(.ROWS(ROWS)) u_row (
        .clk  (clk),
        .rst_n(rst_sync_q),
        .step (row_step),
        .row  (row_addr)
      );
    end else begin : g_norow
      assign row_addr = RW'(0);
    end
  endgenerate

  // WE stays inactive so a CAS-first edge never selects test mode
  assign we_n = 1'b1;

  // R9: the driven row cannot change under an active RAS
  assert_row_stable_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (!ras_n && !$fell(ras_n)) |-> $stable(row_addr));
  // R8: strobes belong to the engine only while busy
  assert_ras_only_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !ras_n |-> busy);
endmodule

// File: tb/sim_refresh_cbr_sched.sv
module sim_refresh_cbr_sched;
  localparam int ROWS  = 8;
  localparam int IVL   = 30;
  localparam int MAXP  = 3;
  localparam int RW    = $clog2(ROWS);

  // {ras_n, cas_n, we_n, busy} per cycle after the grant edge
  localparam logic [3:0] CBR_TBL [8] = '{4'b1011, 4'b0011, 4'b0011, 4'b0111,
                                         4'b0111, 4'b1111, 4'b1111, 4'b1110};
  localparam logic [3:0] RO_TBL  [8] = '{4'b0111, 4'b0111, 4'b0111, 4'b0111,
                                         4'b1111, 4'b1111, 4'b1110, 4'b1110};

  logic clk, rst_n, gnt0, gnt1;
  logic req0, ras0, cas0, we0, busy0, ovf0;
  logic req1, ras1, cas1, we1, busy1, ovf1;
  logic [RW-1:0] row0, row1;
  int errors = 0, checks = 0, cyc = 0;
  int rise_a, rise_b;

  initial clk = 1'b0;
  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  refresh_cbr_sched #(.ROWS(ROWS), .INTERVAL_CYC(IVL), .MAX_PEND(MAXP),
    .CSR_CYC(1), .CHR_CYC(2), .RAS_CYC(4), .RP_CYC(2), .RAS_ONLY(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt0), .ref_req(req0), .ras_n(ras0),
    .cas_n(cas0), .we_n(we0), .row_addr(row0), .busy(busy0), .ovf_err(ovf0));

  refresh_cbr_sched #(.ROWS(ROWS), .INTERVAL_CYC(IVL), .MAX_PEND(MAXP),
    .CSR_CYC(1), .CHR_CYC(2), .RAS_CYC(4), .RP_CYC(2), .RAS_ONLY(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .ref_gnt(gnt1), .ref_req(req1), .ras_n(ras1),
    .cas_n(cas1), .we_n(we1), .row_addr(row1), .busy(busy1), .ovf_err(ovf1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    gnt0 = 1'b0; gnt1 = 1'b0; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R11 strobes in reset u0", {ras0, cas0, we0}, 3'b111);
    chk("R11 flags in reset u0", {busy0, req0, ovf0}, 3'b000);
    chk("R11 flags in reset u1", {ras1, cas1, we1, busy1, req1, ovf1}, 6'b111000);
    rst_n = 1'b1;
  endtask

  task automatic wait_req(input bit sel, output int at);
    while (!(sel ? req1 : req0)) @(negedge clk);
    at = cyc;
  endtask

  task automatic refresh_walk(input bit sel, input int exp_row);
    int t;
    wait_req(sel, t);
    if (sel) gnt1 = 1'b1; else gnt0 = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) begin gnt0 = 1'b0; gnt1 = 1'b0; end
      if (sel) begin
        chk("R9 R7 R8 R6 RAS-only strobe pattern", {ras1, cas1, we1, busy1}, RO_TBL[i]);
        if (i < 4) chk("R9 row stable under RAS", row1, exp_row);
      end else begin
        chk("R4 R5 R6 R7 R8 CBR strobe pattern", {ras0, cas0, we0, busy0}, CBR_TBL[i]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    do_reset();
    // R2: grant with nothing pending is ignored
    gnt0 = 1'b1; gnt1 = 1'b1;
    repeat (3) @(negedge clk);
    chk("R2 grant without request u0", {busy0, ras0, cas0}, 3'b011);
    chk("R2 grant without request u1", {busy1, ras1, cas1}, 3'b011);
    gnt0 = 1'b0; gnt1 = 1'b0;

    // CBR sequences and interval (R1, R10 in CBR mode)
    wait_req(1'b0, rise_a);
    refresh_walk(1'b0, 0);
    chk("R2 req drops after last credit", req0, 1'b0);
    chk("R10 CBR row_addr zero", row0, 0);
    wait_req(1'b0, rise_b);
    chk("R1 interval between credits", rise_b - rise_a, IVL);
    refresh_walk(1'b0, 0);

    // RAS-only sequences and row wrap (R9, R10)
    for (int k = 0; k < 9; k++) begin
      refresh_walk(1'b1, k % ROWS);
      chk("R10 row advances and wraps", row1, (k + 1) % ROWS);
    end

    // R2: stacked credits drain one per grant
    do_reset();
    wait_req(1'b0, rise_a);
    repeat (IVL + 1) @(negedge clk);
    refresh_walk(1'b0, 0);
    chk("R2 one credit left after first grant", req0, 1'b1);
    gnt0 = 1'b1;
    @(negedge clk);
    gnt0 = 1'b0;
    chk("R2 no credit left after second grant", req0, 1'b0);
    repeat (8) @(negedge clk);

    // R3: saturation and sticky overflow
    do_reset();
    wait_req(1'b0, rise_a);
    repeat (3 * IVL - 1) @(negedge clk);
    chk("R3 no overflow while count reaches max", ovf0, 1'b0);
    @(negedge clk);
    chk("R3 overflow on credit past max", ovf0, 1'b1);
    chk("R3 request held while saturated", req0, 1'b1);
    refresh_walk(1'b0, 0);
    chk("R3 overflow stays set after refresh", ovf0, 1'b1);
    do_reset();
    @(negedge clk);
    chk("R3 R11 overflow cleared by reset", ovf0, 1'b0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule